// File: doc/BRIEF.md
# Backpropagation Weight-Update Scaling Unit

This block is the digital front of a neuron training unit. For every neuron of a layer it accepts one quantized error and one quantized dot-product value. It looks up the slope of the activation function for that dot product, multiplies the slope by the signed error, applies a learning-rate right shift and saturates the result. The saturated product sets the pulse duration for the neuron's positive-weight column. Its negation sets the pulse duration for the paired negative-weight column, because that column must move in the opposite direction.

The neurons are served in order by a one-hot select register, which is a shift register. It advances once each time a result leaves the block. After the last neuron's result has been taken, the block pulses a completion flag. The error fed in is normally target minus output for an output layer, or a back-propagated sum for a hidden layer. The digital-to-analog conversion and pulse generation that follow this block are outside it.

Both data paths use valid/ready handshakes. A transfer occurs on a rising clock edge where valid and ready are both high. The input is ready whenever the single output register is empty or is being emptied in the same cycle, so one sample per cycle flows when the consumer never stalls. While the consumer holds ready low, a presented result and its neuron select stay frozen, and new input is refused. The learning-rate shift is a plain control pin that is sampled together with each accepted input.

Top module: `wupd_scaler`

## Requirements
- R1: Bit 7 of `err_in` is the sign (1 = negative) and bits 6:0 are the magnitude. A negative sign with zero magnitude (0x80) acts as zero.
- R2: `dp_in` is two's complement with 4 fraction bits. The slope table returns 64 (meaning 1/4 in units of 1/256) for codes -31 to +31, and 0 for every other code.
- R3: `upd_pos` is the signed error times the slope, arithmetically right-shifted by 4 plus `lr_shift`. The shift rounds toward minus infinity, and the result is then clamped to the range -127 to +127.
- R4: `upd_neg` is always the exact negation of `upd_pos` while `out_valid` is high.
- R5: `in_ready` equals (not `out_valid`) or `out_ready`. An input accepted on one edge appears on the outputs with `out_valid` high right after that edge.
- R6: While `out_valid` is high and `out_ready` is low, `upd_pos`, `upd_neg` and `sel` hold their values.
- R7: `sel` is one-hot, holds bit 0 after reset, and moves up one bit on each output transfer. It returns to bit 0 after the output transfer made while bit NEURONS-1 is set.
- R8: `done` is high for exactly the one cycle that follows the output transfer of neuron NEURONS-1, and is low at all other times.
- R9: After reset, `out_valid` and `done` are low and `sel` equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_shift | input | 3 | Learning-rate right shift, 0 to 7 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| err_in | input | 8 | Sign-magnitude neuron error |
| dp_in | input | 8 | Two's complement dot product, 4 fraction bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| upd_pos | output | 8 | Update for the positive column, two's complement |
| upd_neg | output | 8 | Update for the negative column, two's complement |
| sel | output | NEURONS | One-hot select of the neuron whose result is presented |
| done | output | 1 | One-cycle pulse after the last neuron's result is taken |

## Verification
A result is due one clock after its input transfer. The select moves one clock after an output transfer, and `done` rises one clock after the final neuron's transfer. `in_ready` is a combinational function of the current cycle's state and `out_ready`. The bench steps a behavioural model on each rising edge, using only the values it drove itself. It then compares every output to the model a quarter period later, when both the registers and `out_ready` are stable. The stimulus covers sign and zero-magnitude errors, slope-table edges at codes ±31 and ±32, saturation, every shift, and consumer stalls.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
  localparam int ERR_W   = 8;
  localparam int DP_W    = 8;
  localparam int SLOPE_W = 8;
  localparam int UPD_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int FRAC_SH = 4;
  localparam logic [SLOPE_W-1:0] SLOPE_IN = 8'd64;
  localparam int DP_LIMIT = 32;

  typedef struct packed {
    logic signed [UPD_W-1:0] pos;
    logic signed [UPD_W-1:0] neg;
  } upd_pair_t;
endpackage

// File: rtl/wupd_slope_lut.sv
module wupd_slope_lut
  import wupd_pkg::*;
(
  input  logic [DP_W-1:0]    dp,
  output logic [SLOPE_W-1:0] slope
);
  localparam int ENTRIES = 1 << DP_W;
  logic [SLOPE_W-1:0] table_q [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_tbl
    localparam int SV = (gi >= ENTRIES/2) ? gi - ENTRIES : gi;
    assign table_q[gi] = (SV > -DP_LIMIT && SV < DP_LIMIT) ? SLOPE_IN : '0;
  end

  assign slope = table_q[dp];
endmodule

// File: rtl/wupd_scale.sv
module wupd_scale
  import wupd_pkg::*;
(
  input  logic [ERR_W-1:0]   err,
  input  logic [SLOPE_W-1:0] slope,
  input  logic [SHIFT_W-1:0] lr,
  output upd_pair_t          res
);
  localparam int MAG_W  = ERR_W - 1;
  localparam int PROD_W = ERR_W + SLOPE_W + 1;
  localparam int SMAX   = (1 << (UPD_W-1)) - 1;

  logic signed [ERR_W:0]    err_s;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;
  logic [SHIFT_W:0]         amount;
  logic signed [UPD_W-1:0]  sat;

  always_comb begin
    err_s = err[ERR_W-1] ? -$signed({2'b00, err[MAG_W-1:0]})
                         :  $signed({2'b00, err[MAG_W-1:0]});
    prod    = PROD_W'(err_s) * $signed({{(PROD_W-SLOPE_W){1'b0}}, slope});
    amount  = (SHIFT_W+1)'(FRAC_SH) + {1'b0, lr};
    shifted = prod >>> amount;
    if (shifted > PROD_W'(SMAX))       sat = UPD_W'(SMAX);
    else if (shifted < -PROD_W'(SMAX)) sat = -UPD_W'(SMAX);
    else                               sat = shifted[UPD_W-1:0];
    res.pos = sat;
    res.neg = -sat;
  end
endmodule

// File: rtl/wupd_seq.sv
module wupd_seq #(
  parameter int NEURONS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  output logic [NEURONS-1:0] sel,
  output logic               done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= NEURONS'(1);
      done <= 1'b0;
    end else begin
      done <= step && sel[NEURONS-1];
      if (step) sel <= sel[NEURONS-1] ? NEURONS'(1) : (sel << 1);
    end
  end
endmodule

// File: rtl/wupd_scaler.sv
module wupd_scaler
  import wupd_pkg::*;
#(
  parameter int NEURONS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         lr_shift,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         err_in,
  input  logic [7:0]         dp_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         upd_pos,
  output logic [7:0]         upd_neg,
  output logic [NEURONS-1:0] sel,
  output logic               done
);
  logic [SLOPE_W-1:0] slope;
  upd_pair_t          next_res, res_q;
  logic               take_in, take_out;

  wupd_slope_lut u_lut (.dp(dp_in), .slope(slope));
  wupd_scale u_scale (.err(err_in), .slope(slope), .lr(lr_shift), .res(next_res));
  wupd_seq #(.NEURONS(NEURONS)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(take_out), .sel(sel), .done(done));

  assign in_ready = !out_valid || out_ready;
  assign take_in  = in_valid && in_ready;
  assign take_out = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (take_in) begin
      out_valid <= 1'b1;
      res_q     <= next_res;
    end else if (take_out) begin
      out_valid <= 1'b0;
    end
  end

  assign upd_pos = res_q.pos;
  assign upd_neg = res_q.neg;
endmodule

// File: rtl/wupd_scaler_chk.sv
module wupd_scaler_chk #(
  parameter int NEURONS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         upd_pos,
  input logic [7:0]         upd_neg,
  input logic [NEURONS-1:0] sel,
  input logic               done
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(sel)); // R7
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !sel[NEURONS-1]) |=> (sel == ($past(sel) << 1))); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(upd_pos) && $stable(upd_neg) && $stable(sel) && out_valid)); // R6
  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (8'(upd_pos + upd_neg) == 8'd0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (upd_pos != 8'h80)); // R3
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && sel[NEURONS-1])); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind wupd_scaler wupd_scaler_chk #(.NEURONS(NEURONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .upd_pos(upd_pos), .upd_neg(upd_neg), .sel(sel), .done(done));

// File: tb/wupd_scaler_test.sv
module wupd_scaler_test;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [2:0] lr_shift = 0;
  logic in_valid = 0, out_ready = 1;
  logic [7:0] err_in = 0, dp_in = 0;
  logic in_ready, out_valid, done;
  logic [7:0] upd_pos, upd_neg;
  logic [N-1:0] sel;
  int compared = 0, mismatched = 0;
  int ready_mode = 0;

  wupd_scaler #(.NEURONS(N)) uut (.*);

  always #10 clk = ~clk;

  // behavioural reference
  bit mv = 0, mdone = 0, m_in_acc = 0;
  int msel = 0, mpos = 0;

  function automatic int expect_pos(logic [7:0] e, logic [7:0] d, int lr);
    int ev, dv, p;
    ev = e[7] ? -int'(e[6:0]) : int'(e[6:0]);            // R1
    dv = int'($signed(d));
    p  = ev * ((dv > -32 && dv < 32) ? 64 : 0);          // R2
    p  = p >>> (4 + lr);                                 // R3
    if (p > 127) p = 127;
    if (p < -127) p = -127;
    return p;
  endfunction

  always @(posedge clk) begin
    bit oacc;
    if (!rst_n) begin
      mv = 0; mdone = 0; msel = 0; m_in_acc = 0;
    end else begin
      m_in_acc = in_valid && (!mv || out_ready);
      oacc = mv && out_ready;
      mdone = oacc && (msel == N-1);
      if (oacc) msel = (msel == N-1) ? 0 : msel + 1;
      if (m_in_acc) begin
        mv = 1; mpos = expect_pos(err_in, dp_in, int'(lr_shift));
      end else if (oacc) mv = 0;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk(in_ready == (!mv || out_ready), "R5", "in_ready", int'(in_ready), int'(!mv || out_ready));
      chk(out_valid == mv, "R5", "out_valid", int'(out_valid), int'(mv));
      chk(sel == N'(1 << msel), "R7", "sel", int'(sel), 1 << msel);
      chk(done == mdone, "R8", "done", int'(done), int'(mdone));
      if (mv) begin
        chk(int'($signed(upd_pos)) == mpos, "R3", "upd_pos", int'($signed(upd_pos)), mpos);
        chk(int'($signed(upd_neg)) == -mpos, "R4", "upd_neg", int'($signed(upd_neg)), -mpos);
      end
    end
  end

  always @(negedge clk) begin
    case (ready_mode)
      0: out_ready <= 1;
      1: out_ready <= ($urandom % 2) != 0;
      default: out_ready <= ($urandom % 4) == 0;
    endcase
  end

  task automatic send(logic [7:0] e, logic [7:0] d, logic [2:0] lr);
    @(negedge clk);
    in_valid = 1; err_in = e; dp_in = d; lr_shift = lr;
    do begin
      @(posedge clk); #1;
    end while (!m_in_acc);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R9: reset state
    chk(out_valid == 0, "R9", "out_valid", int'(out_valid), 0);
    chk(done == 0, "R9", "done", int'(done), 0);
    chk(sel == N'(1), "R9", "sel", int'(sel), 1);
    @(negedge clk); rst_n = 1;
    // R1 sign/zero, R2 table edges, R3 saturation and shift
    send(8'h05, 8'h00, 0);   // +5*64>>4 = 20
    send(8'h85, 8'h10, 0);   // -20
    send(8'h80, 8'h00, 0);   // R1 negative zero -> 0
    send(8'h7F, 8'h00, 0);   // R3 saturate to 127
    send(8'hFF, 8'h00, 0);   // R3 saturate to -127
    send(8'h10, 8'd31, 0);   // R2 inside edge
    send(8'h10, 8'd32, 0);   // R2 outside edge -> 0
    send(8'h10, 8'hE1, 0);   // R2 -31 inside
    send(8'h10, 8'hE0, 0);   // R2 -32 outside
    send(8'h83, 8'h00, 3);   // R3 floor: -192>>7 = -2
    for (int lr = 0; lr < 8; lr++) send(8'h6A, 8'h04, 3'(lr));
    // R6 stalls, R7/R8 wrap
    ready_mode = 2;
    for (int i = 0; i < 40; i++) send(8'($urandom), 8'($urandom % 80), 3'($urandom));
    ready_mode = 1;
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) @(negedge clk);
      send(8'($urandom), 8'($urandom), 3'($urandom));
    end
    ready_mode = 0;
    for (int i = 0; i < 24; i++) send(8'($urandom), 8'($urandom % 64), 3'($urandom % 3));
    repeat (5) @(posedge clk);
    #5;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule